// File: doc/BRIEF.md
# Two-Branch Allpass Half-Band Decimator

This block halves the sample rate of a stream of signed 16-bit audio samples. It does not use a tapped delay line. Incoming samples are dealt out alternately to two branches. Each branch is a chain of three first-order allpass sections that run in fixed-point arithmetic on 32-bit state words. After every second sample the two branch outputs are added together, halved with rounding and clipped to 16 bits. The result is one output sample for every input pair.

Both sides of the block are valid/ready streams. The input side stalls whenever a finished output is still waiting to be taken, so no sample is ever lost. A synchronous clear input returns the filter to a known starting point: the eight state words go to zero and the pair phase points back at the first branch. This lets a new stream start without any history from the previous one.

Top module: `allpass_decim2`

## Requirements
- R1: An accepted sample is sign-extended to 32 bits and multiplied by 1024 (shifted left by 10) before it enters a branch.
- R2: After reset or clear, the first accepted sample of each pair goes to the first branch, with coefficients 12199, 37471 and 60255. The second goes to the second branch, with coefficients 3284, 24441 and 49528.
- R3: Each section returns base + floor(c·(a − p) / 65536). Here c is an unsigned 16-bit coefficient and (a − p) is a signed 32-bit difference. The product is exact, and every add and subtract wraps at 32 bits.
- R4: Within a branch holding states (s0, s1, s2, s3) and input x, the sections run in this order: t1 = sec(c0, x, s0, s1), then t2 = sec(c1, t1, s1, s2), then s3' = sec(c2, t2, s2, s3). The new states are (x, t1, t2, s3'). The first branch holds words 0–3 and the second branch holds words 4–7.
- R5: The combined value is (s3 + s7 + 1024) >>> 11, computed with 32-bit wrap. It uses the final state word of each branch after the second sample of the pair has been processed.
- R6: The combined value is saturated to the range −32768 to 32767 before it is output.
- R7: out_valid rises in the cycle after the second sample of a pair is accepted, and only then. Accepting the first sample of a pair never creates an output.
- R8: While out_valid is high and out_ready is low, in_ready is low, and out_valid and out_data hold their values.
- R9: A cycle with clr high zeroes all state words, sends the next accepted sample to the first branch, and drops any pending output. During that cycle in_ready is low, so in_valid is ignored.
- R10: While rst_n is low at a clock edge, the block takes the same state as after a clear, and out_data is 0. After reset, in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear of filter state and pair phase |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take an input sample |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | Output sample available |
| out_ready | input | 1 | Consumer takes the output sample |
| out_data | output | 16 | Signed decimated output sample |

## Verification
The assertions assume that the consumer follows the usual stream rule: a pending output counts as taken only in a cycle where out_ready is high. They also assume that clr arrives only as a clean one-cycle or multi-cycle pulse and is never tied to reset. The stimulus drives every input once per cycle, just after the active edge. It changes out_ready only at that point, and it asserts clr only between samples and with out_ready low. This keeps the question of whether a pending output was taken or dropped unambiguous. The input patterns cover an impulse, a ramp, full-scale steps in both directions, random data with random gaps, random backpressure, a clear between the two samples of a pair, and a reset in mid-stream.

// File: rtl/dec2_pkg.sv
// Shared widths and fixed coefficients of the two-branch allpass decimator.
// Assumes three sections per branch; coefficients are unsigned Q0.16 fractions.
package dec2_pkg;
    localparam int SAMPLE_W = 16;
    localparam int STATE_W  = 32;
    localparam int COEF_W   = 16;
    localparam int FRAC_W   = 16;
    localparam int N_SEC    = 3;
    localparam int IN_SHIFT = 10;
    localparam int OUT_SHIFT = 11;

    // Coefficients of the first (even-sample) branch, section 0 in the low bits.
    localparam logic [N_SEC*COEF_W-1:0] BRANCH_A_COEFS =
        {16'd60255, 16'd37471, 16'd12199};
    // Coefficients of the second (odd-sample) branch, section 0 in the low bits.
    localparam logic [N_SEC*COEF_W-1:0] BRANCH_B_COEFS =
        {16'd49528, 16'd24441, 16'd3284};
endpackage

// File: rtl/ap_section.sv
// One first-order allpass step: y = base + floor(coef * (a - partner) / 2^FRAC_W).
// Assumes coef is unsigned; the product is formed at full width so it is exact
// before the arithmetic shift, and all 32-bit adds wrap.
module ap_section #(
    parameter int STATE_W = 32,
    parameter int COEF_W  = 16,
    parameter int FRAC_W  = 16
) (
    input  logic signed [STATE_W-1:0] base,
    input  logic signed [STATE_W-1:0] a_in,
    input  logic signed [STATE_W-1:0] partner,
    input  logic        [COEF_W-1:0]  coef,
    output logic signed [STATE_W-1:0] y
);
    localparam int PROD_W = STATE_W + COEF_W + 1;

    logic signed [STATE_W-1:0] diff;
    logic signed [PROD_W-1:0]  diff_ext;
    logic signed [PROD_W-1:0]  coef_ext;
    logic signed [PROD_W-1:0]  prod;
    logic signed [PROD_W-1:0]  prod_sh;

    // Wrapped difference, exact signed product, floor-scaling and wrapped sum.
    always_comb begin
        diff     = a_in - partner;
        diff_ext = $signed({{(PROD_W-STATE_W){diff[STATE_W-1]}}, diff});
        coef_ext = $signed({{(PROD_W-COEF_W){1'b0}}, coef});
        prod     = diff_ext * coef_ext;
        prod_sh  = prod >>> FRAC_W;
        y        = base + prod_sh[STATE_W-1:0];
    end
endmodule

// File: rtl/ap_branch.sv
// A chain of N_SEC allpass sections with N_SEC+1 state words.
// Section k reads state k and k+1; on enable, state k takes the value entering
// section k, and the last word takes the chain result. Assumes clr and reset
// have priority over enable.
module ap_branch #(
    parameter int STATE_W = 32,
    parameter int COEF_W  = 16,
    parameter int FRAC_W  = 16,
    parameter int N_SEC   = 3,
    parameter logic [N_SEC*COEF_W-1:0] COEFS = '0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      en,
    input  logic signed [STATE_W-1:0] x,
    output logic signed [STATE_W-1:0] y_next,
    output logic signed [STATE_W-1:0] y_q
);
    logic signed [STATE_W-1:0] st  [N_SEC+1];
    logic signed [STATE_W-1:0] stg [N_SEC+1];

    assign stg[0] = x;

    for (genvar k = 0; k < N_SEC; k++) begin : g_sec
        ap_section #(
            .STATE_W (STATE_W),
            .COEF_W  (COEF_W),
            .FRAC_W  (FRAC_W)
        ) u_sec (
            .base    (st[k]),
            .a_in    (stg[k]),
            .partner (st[k+1]),
            .coef    (COEFS[k*COEF_W +: COEF_W]),
            .y       (stg[k+1])
        );
    end

    // State words: zero on reset or clear, shift in the stage values on enable.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int k = 0; k <= N_SEC; k++) st[k] <= '0;
        end else if (en) begin
            for (int k = 0; k <= N_SEC; k++) st[k] <= stg[k];
        end
    end

    assign y_next = stg[N_SEC];
    assign y_q    = st[N_SEC];
endmodule

// File: rtl/dec2_combine.sv
// Adds two branch results, rounds, shifts right by RND_SH and saturates to OUT_W.
// Assumes RND_SH >= 1 and OUT_W < STATE_W; the sum wraps at STATE_W bits.
module dec2_combine #(
    parameter int STATE_W = 32,
    parameter int OUT_W   = 16,
    parameter int RND_SH  = 11
) (
    input  logic signed [STATE_W-1:0] a,
    input  logic signed [STATE_W-1:0] b,
    output logic signed [OUT_W-1:0]   y
);
    localparam logic signed [STATE_W-1:0] HALF  = STATE_W'(1) <<< (RND_SH - 1);
    localparam logic signed [STATE_W-1:0] MAX_V = STATE_W'((64'sd1 <<< (OUT_W - 1)) - 1);
    localparam logic signed [STATE_W-1:0] MIN_V = -MAX_V - 1;

    logic signed [STATE_W-1:0] sum;
    logic signed [STATE_W-1:0] scaled;

    // Round-half-up, arithmetic shift, then clip to the output range.
    always_comb begin
        sum    = a + b + HALF;
        scaled = sum >>> RND_SH;
        if (scaled > MAX_V)      y = MAX_V[OUT_W-1:0];
        else if (scaled < MIN_V) y = MIN_V[OUT_W-1:0];
        else                     y = scaled[OUT_W-1:0];
    end
endmodule

// File: rtl/allpass_decim2.sv
// Streaming decimate-by-two filter built from two allpass branches.
// Even samples of each pair update branch A, odd samples update branch B and
// trigger one registered output. Assumes the consumer obeys valid/ready; the
// input stalls while an untaken output is pending.
module allpass_decim2 #(
    parameter int SAMPLE_W  = dec2_pkg::SAMPLE_W,
    parameter int STATE_W   = dec2_pkg::STATE_W,
    parameter int COEF_W    = dec2_pkg::COEF_W,
    parameter int FRAC_W    = dec2_pkg::FRAC_W,
    parameter int N_SEC     = dec2_pkg::N_SEC,
    parameter int IN_SHIFT  = dec2_pkg::IN_SHIFT,
    parameter int OUT_SHIFT = dec2_pkg::OUT_SHIFT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_data,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [SAMPLE_W-1:0] out_data
);
    localparam int EXT_W = STATE_W - SAMPLE_W - IN_SHIFT;

    logic                      phase_q;
    logic                      accept;
    logic                      en_a;
    logic                      en_b;
    logic signed [STATE_W-1:0] x_scaled;
    logic signed [STATE_W-1:0] a_next;
    logic signed [STATE_W-1:0] a_q;
    logic signed [STATE_W-1:0] b_next;
    logic signed [STATE_W-1:0] b_q;
    logic signed [SAMPLE_W-1:0] comb_y;

    // Input handshake: blocked during clear and while an output waits.
    assign in_ready = !clr && !(out_valid && !out_ready);
    assign accept   = in_valid && in_ready;
    assign en_a     = accept && !phase_q;
    assign en_b     = accept && phase_q;

    // Sign-extend and scale the sample into the state format.
    assign x_scaled = $signed({{EXT_W{in_data[SAMPLE_W-1]}}, in_data, {IN_SHIFT{1'b0}}});

    ap_branch #(
        .STATE_W (STATE_W),
        .COEF_W  (COEF_W),
        .FRAC_W  (FRAC_W),
        .N_SEC   (N_SEC),
        .COEFS   (dec2_pkg::BRANCH_A_COEFS)
    ) u_branch_a (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .en     (en_a),
        .x      (x_scaled),
        .y_next (a_next),
        .y_q    (a_q)
    );

    ap_branch #(
        .STATE_W (STATE_W),
        .COEF_W  (COEF_W),
        .FRAC_W  (FRAC_W),
        .N_SEC   (N_SEC),
        .COEFS   (dec2_pkg::BRANCH_B_COEFS)
    ) u_branch_b (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .en     (en_b),
        .x      (x_scaled),
        .y_next (b_next),
        .y_q    (b_q)
    );

    // Branch A already holds this pair's result; branch B's is formed this cycle.
    dec2_combine #(
        .STATE_W (STATE_W),
        .OUT_W   (SAMPLE_W),
        .RND_SH  (OUT_SHIFT)
    ) u_combine (
        .a (a_q),
        .b (b_next),
        .y (comb_y)
    );

    // Pair phase and output register with its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            phase_q   <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            if (accept) phase_q <= !phase_q;
            if (en_b) begin
                out_valid <= 1'b1;
                out_data  <= comb_y;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end

    logic unused_ok;
    assign unused_ok = ^{a_next, b_q};
endmodule

// File: rtl/dec2_checker.sv
// Protocol and sequencing properties of allpass_decim2, attached by bind.
// Assumes synchronous active-low reset; all properties are disabled under it.
module dec2_checker #(
    parameter int SAMPLE_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                clr,
    input logic                in_valid,
    input logic                in_ready,
    input logic                out_valid,
    input logic                out_ready,
    input logic [SAMPLE_W-1:0] out_data,
    input logic                phase
);
    a_r8_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    a_r8_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !clr) |=> (out_valid && $stable(out_data)));

    a_r7_pair_end_gives_output: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && phase) |=> out_valid);

    a_r7_pair_start_no_output: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !phase && (!out_valid || out_ready)) |=> !out_valid);

    a_r9_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!out_valid && !phase));

    a_r9_clear_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> !in_ready);
endmodule

bind allpass_decim2 dec2_checker #(.SAMPLE_W(SAMPLE_W)) u_dec2_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .phase     (phase_q)
);

// File: tb/tb_allpass_decim2.sv
`timescale 1ns/1ps
module tb_allpass_decim2;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [15:0] out_data;

    int checks = 0;
    int errors = 0;
    int sat_hits = 0;
    bit done = 0;
    int ready_mode = 0;   // 0: always ready, 1: random, 2: held low

    // Behavioural reference state
    int st[8];
    bit ph;
    int exp_q[$];

    allpass_decim2 dut (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    // R3: floor(c*(a-p)/65536) added to base, 32-bit wrap
    function automatic int sec(input int c, input int a, input int base, input int p);
        int d;
        longint prod;
        d = a - p;
        prod = longint'(c) * longint'(d);
        return base + int'(prod >>> 16);
    endfunction

    function automatic void model_clear();
        foreach (st[i]) st[i] = 0;
        ph = 0;
        exp_q.delete();
    endfunction

    // R1, R2, R4, R5, R6 in behavioural form
    function automatic void model_step(input logic [15:0] s);
        int x, b, t1, t2, t3, sum, o;
        int c0, c1, c2;
        x = int'($signed(s)) * 1024;
        if (!ph) begin b = 0; c0 = 12199; c1 = 37471; c2 = 60255; end
        else     begin b = 4; c0 = 3284;  c1 = 24441; c2 = 49528; end
        t1 = sec(c0, x,  st[b],   st[b+1]);
        t2 = sec(c1, t1, st[b+1], st[b+2]);
        t3 = sec(c2, t2, st[b+2], st[b+3]);
        st[b] = x; st[b+1] = t1; st[b+2] = t2; st[b+3] = t3;
        if (ph) begin
            sum = st[3] + st[7] + 1024;
            o = sum >>> 11;
            if (o > 32767) o = 32767;
            if (o < -32768) o = -32768;
            exp_q.push_back(o);
        end
        ph = !ph;
    endfunction

    // Compare and advance the reference away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            model_clear();
        end else if (!done) begin
            chk(out_valid == (exp_q.size() != 0), "R7 out_valid", out_valid, exp_q.size() != 0);
            if (out_valid && !out_ready) chk(!in_ready, "R8 in_ready during stall", in_ready, 0);
            if (clr) chk(!in_ready, "R9 in_ready during clear", in_ready, 0);
            if (out_valid && out_ready && exp_q.size() != 0) begin
                int e;
                e = exp_q.pop_front();
                chk($signed(out_data) == e, "R1/R2/R3/R4/R5/R6 out_data",
                    longint'($signed(out_data)), e);
                if (e == 32767 || e == -32768) sat_hits++;
            end
            if (clr) model_clear();
            else if (in_valid && in_ready) model_step(in_data);
        end
    end

    // Consumer side readiness, updated just after each edge.
    always @(posedge clk) begin
        #1;
        case (ready_mode)
            0: out_ready <= 1'b1;
            1: out_ready <= ($urandom % 3) != 0;
            default: out_ready <= 1'b0;
        endcase
    end

    task automatic send(input logic [15:0] s);
        bit taken;
        in_valid = 1'b1;
        in_data  = s;
        taken = 0;
        while (!taken) begin
            @(negedge clk);
            taken = in_ready;
            @(posedge clk);
            #1;
        end
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic do_clear();
        clr = 1'b1;
        @(posedge clk); #1;
        clr = 1'b0;
    endtask

    initial begin
        model_clear();
        repeat (4) @(posedge clk);
        #1;
        // R10: reset state
        @(negedge clk);
        chk(out_valid == 0, "R10 out_valid after reset", out_valid, 0);
        chk(out_data == 0, "R10 out_data after reset", out_data, 0);
        chk(in_ready == 1, "R10 in_ready after reset", in_ready, 1);
        @(posedge clk); #1;
        rst_n = 1'b1;
        idle(2);

        // Impulse then zeros
        send(16'sd16000);
        for (int i = 0; i < 41; i++) send(16'd0);
        // Ramp
        for (int i = 0; i < 64; i++) send(16'(i * 500 - 16000));
        // Full-scale steps in both directions (R6)
        for (int i = 0; i < 40; i++) send(16'h8000);
        for (int i = 0; i < 40; i++) send(16'h7FFF);
        for (int i = 0; i < 40; i++) send(16'h8000);
        for (int i = 0; i < 40; i++) send(i[0] ? 16'h7FFF : 16'h8000);

        // Random data with gaps and backpressure (R8)
        ready_mode = 1;
        for (int i = 0; i < 400; i++) begin
            send(16'($urandom));
            if ($urandom % 4 == 0) idle(1);
        end

        // Held output: stall for several cycles (R8)
        ready_mode = 2;
        idle(2);
        send(16'sd1200);
        send(16'sd2400);
        in_valid = 1'b1; in_data = 16'sd999;
        idle(6);
        in_valid = 1'b0;
        ready_mode = 0;
        idle(3);

        // Clear between the two samples of a pair (R9)
        send(16'sd20000);
        ready_mode = 2; idle(1);
        do_clear();
        @(negedge clk);
        chk(out_valid == 0, "R9 no output after clear", out_valid, 0);
        @(posedge clk); #1;
        ready_mode = 0;
        for (int i = 0; i < 60; i++) send(16'($urandom));

        // Clear with a pending output (R9)
        ready_mode = 2; idle(1);
        send(16'sd3000); send(16'sd3000);
        do_clear();
        ready_mode = 0;
        for (int i = 0; i < 20; i++) send(16'sd7000);

        // Reset mid-stream (R10)
        send(16'sd5000);
        rst_n = 1'b0;
        idle(2);
        @(negedge clk);
        chk(out_valid == 0, "R10 out_valid after mid-run reset", out_valid, 0);
        chk(out_data == 0, "R10 out_data after mid-run reset", out_data, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        for (int i = 0; i < 30; i++) send(16'($urandom));
        idle(8);

        chk(sat_hits > 0, "R6 saturated outputs seen", sat_hits, 1);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule